// File: doc/BRIEF.md
# I2C Master Start and Repeated-Start Sequencer

This block produces the START and repeated-START conditions that a master I2C controller places on the bus. Control logic raises one of two request strobes. The sequencer keeps the request pending until the bus state permits it. It then steps through a fixed series of pin phases on open-drain SCL and SDA pull-down enables. The high phase and the low phase of each sequence are timed by two programmable count inputs. Hold and setup margins are fixed parameters, counted in the same clock cycles as the programmable periods.

Every phase that follows a release or pull of SCL first waits for the synchronised line to reach the new level, and only then starts its count. A slave that stretches the clock, or another master that holds SCL low, therefore lengthens the phase and does not shorten it. When a sequence ends, a single-cycle `cond_done` strobe tells the surrounding controller to enter master-transmit mode and begin the address byte. The strobe also clears the request that was served. Byte shifting, acknowledge handling, arbitration and STOP are handled elsewhere. The block has no data path, so there is no valid/ready interface. All of its pins are plain control and status signals.

Top module: `i2c_cond_seq`

## Requirements
- R1: A one-cycle `start_set` sets `start_pend`. A pending start launches only in a cycle where `bus_busy` is 0. While the bus is busy, the request stays pending without error and both pulls stay released.
- R2: A one-cycle `restart_set` sets `restart_pend`. A pending restart launches only when `bus_busy` is 1 and `master_mode` is 1. Otherwise it stays pending and both pulls stay released.
- R3: In a start, `sda_pull` (1 = pull low) rises while `scl_pull` is 0. `scl_pull` rises exactly `high_cnt + HOLD_CYC` cycles after `sda_pull` rises.
- R4: After `scl_pull` rises, the block waits until the SCL input, passed through a 2-flop synchroniser, reads low. It then counts `max(low_cnt,1)` cycles. With an unobstructed line, `cond_done` is seen `max(low_cnt,1) + 3` cycles after `scl_pull` rises.
- R5: A restart begins by asserting `scl_pull` with `sda_pull` released. It releases `scl_pull` after `max(low_cnt,1)` cycles.
- R6: After the SCL release in a restart, the block waits for the synchronised SCL to read high and then counts `SETUP_CYC` cycles before it raises `sda_pull`. The interval is `SETUP_CYC + 3 + X` cycles, where X is the number of cycles an external agent keeps SCL low after the release.
- R7: After the setup interval, a restart finishes with the same hold, SCL-fall and low-count phases as R3 and R4.
- R8: `cond_done` is high for exactly one cycle at the end of each sequence. In that same edge, the pending bit of the served request clears. A set strobe that lands on that edge keeps the bit pending.
- R9: `busy` is high from the cycle after launch until the cycle before `cond_done`. A start spans `high_cnt + HOLD_CYC + max(low_cnt,1) + 3` busy cycles.
- R10: A synchronous `rst` releases both pulls, clears both pending bits, drops `busy` and returns the sequencer to idle, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_set | input | 1 | One-cycle strobe requesting a START |
| restart_set | input | 1 | One-cycle strobe requesting a repeated START |
| bus_busy | input | 1 | Bus occupied (from the bus monitor) |
| master_mode | input | 1 | This node currently owns the bus |
| high_cnt | input | CW | SCL high-phase count |
| low_cnt | input | CW | SCL low-phase count |
| scl_in | input | 1 | Raw level of the SCL line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| start_pend | output | 1 | START request pending |
| restart_pend | output | 1 | Repeated-START request pending |
| busy | output | 1 | A sequence is in progress |
| cond_done | output | 1 | One-cycle end-of-sequence strobe; enter master-transmit |

## Verification
The bench builds the block with 4-bit period inputs, a hold margin of 2 and a setup margin of 3. This makes the full 16 by 16 grid of high and low counts cheap to sweep, for both starts and restarts, including the zero low count that is clamped to one cycle. In the small build the bench can also hold SCL low after the restart release for several lengths, and can place a new request strobe on the exact edge that ends a sequence. The gating tests, the reset in mid-sequence and the stretch cases all compare phase intervals measured at the pins with intervals computed from the counts and margins.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_RS_LOW,
    CS_RS_RISE,
    CS_RS_SETUP,
    CS_SDA_HOLD,
    CS_SCL_FALL,
    CS_LOW_CNT
  } cond_state_e;

  localparam int unsigned KIND_START   = 0;
  localparam int unsigned KIND_RESTART = 1;
endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int unsigned W        = 1,
  parameter logic        RST_LVL  = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= RST_LVL;
          s2 <= RST_LVL;
        end else begin
          s1 <= din[gi];
          s2 <= s1;
        end
      end
      assign dout[gi] = s2;
    end
  endgenerate
endmodule

// File: rtl/cond_timer.sv
module cond_timer #(
  parameter int unsigned TW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (cnt > TW'(1))     cnt <= cnt - TW'(1);
  end

  // a phase loaded with V lasts max(V,1) cycles
  assign expire = (cnt <= TW'(1));
endmodule

// File: rtl/cond_req.sv
module cond_req #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_req
      logic p;
      always_ff @(posedge clk) begin
        if (rst) p <= 1'b0;
        else     p <= (p & ~clr[gi]) | set[gi];
      end
      assign pend[gi] = p;
    end
  endgenerate
endmodule

// File: rtl/cond_fsm.sv
module cond_fsm
  import i2c_cond_pkg::*;
#(
  parameter int unsigned CW        = 8,
  parameter int unsigned HOLD_CYC  = 4,
  parameter int unsigned SETUP_CYC = 5,
  localparam int unsigned TW       = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    pend,
  input  logic          bus_busy,
  input  logic          master_mode,
  input  logic [CW-1:0] high_cnt,
  input  logic [CW-1:0] low_cnt,
  input  logic          scl_s,
  input  logic          expire,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic [1:0]    req_clr,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          cond_done
);
  cond_state_e st, st_n;
  logic        kind, kind_n;
  logic        done_n;
  logic [TW-1:0] hold_len, low_len;

  assign hold_len = TW'(high_cnt) + TW'(HOLD_CYC);
  assign low_len  = TW'(low_cnt);

  always_comb begin
    st_n     = st;
    kind_n   = kind;
    tmr_load = 1'b0;
    tmr_val  = '0;
    done_n   = 1'b0;
    req_clr  = '0;
    unique case (st)
      CS_IDLE: begin
        if (pend[KIND_START] && !bus_busy) begin
          st_n     = CS_SDA_HOLD;
          kind_n   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = hold_len;
        end else if (pend[KIND_RESTART] && bus_busy && master_mode) begin
          st_n     = CS_RS_LOW;
          kind_n   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = low_len;
        end
      end
      CS_RS_LOW:   if (expire) st_n = CS_RS_RISE;
      CS_RS_RISE: begin
        if (scl_s) begin
          st_n     = CS_RS_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETUP_CYC);
        end
      end
      CS_RS_SETUP: begin
        if (expire) begin
          st_n     = CS_SDA_HOLD;
          tmr_load = 1'b1;
          tmr_val  = hold_len;
        end
      end
      CS_SDA_HOLD: if (expire) st_n = CS_SCL_FALL;
      CS_SCL_FALL: begin
        if (!scl_s) begin
          st_n     = CS_LOW_CNT;
          tmr_load = 1'b1;
          tmr_val  = low_len;
        end
      end
      CS_LOW_CNT: begin
        if (expire) begin
          st_n          = CS_IDLE;
          done_n        = 1'b1;
          req_clr[kind] = 1'b1;
        end
      end
      default: st_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CS_IDLE;
      kind      <= 1'b0;
      cond_done <= 1'b0;
    end else begin
      st        <= st_n;
      kind      <= kind_n;
      cond_done <= done_n;
    end
  end

  assign scl_pull = (st == CS_RS_LOW) || (st == CS_SCL_FALL) || (st == CS_LOW_CNT);
  assign sda_pull = (st == CS_SDA_HOLD) || (st == CS_SCL_FALL) || (st == CS_LOW_CNT);
  assign busy     = (st != CS_IDLE);
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int unsigned CW        = 8,
  parameter int unsigned HOLD_CYC  = 4,
  parameter int unsigned SETUP_CYC = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_set,
  input  logic          restart_set,
  input  logic          bus_busy,
  input  logic          master_mode,
  input  logic [CW-1:0] high_cnt,
  input  logic [CW-1:0] low_cnt,
  input  logic          scl_in,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          start_pend,
  output logic          restart_pend,
  output logic          busy,
  output logic          cond_done
);
  localparam int unsigned TW = CW + 1;

  logic [1:0]    pend, clr;
  logic          scl_s, expire, tmr_load;
  logic [TW-1:0] tmr_val;

  cond_sync #(.W(1), .RST_LVL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s)
  );

  cond_req #(.N(2)) u_req (
    .clk(clk), .rst(rst), .set({restart_set, start_set}), .clr(clr), .pend(pend)
  );

  cond_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  cond_fsm #(.CW(CW), .HOLD_CYC(HOLD_CYC), .SETUP_CYC(SETUP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pend(pend), .bus_busy(bus_busy),
    .master_mode(master_mode), .high_cnt(high_cnt), .low_cnt(low_cnt),
    .scl_s(scl_s), .expire(expire), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .req_clr(clr), .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
    .cond_done(cond_done)
  );

  assign start_pend   = pend[0];
  assign restart_pend = pend[1];
endmodule

// File: rtl/i2c_cond_seq_chk.sv
module i2c_cond_seq_chk (
  input logic clk,
  input logic rst,
  input logic bus_busy,
  input logic master_mode,
  input logic scl_pull,
  input logic sda_pull,
  input logic start_pend,
  input logic restart_pend,
  input logic busy,
  input logic cond_done
);
  // R3
  sda_fall_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_pull);

  // R3
  scl_after_sda_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_pull) && !$rose(busy)) |-> sda_pull);

  // R5
  restart_opens_sda_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && scl_pull) |-> !sda_pull);

  // R1 and R2
  launch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past((start_pend && !bus_busy) ||
                          (restart_pend && bus_busy && master_mode)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    cond_done |=> !cond_done);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cond_done |-> ($past(busy) && !busy));
endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
  .clk(clk), .rst(rst), .bus_busy(bus_busy), .master_mode(master_mode),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .start_pend(start_pend),
  .restart_pend(restart_pend), .busy(busy), .cond_done(cond_done)
);

// File: tb/tb_i2c_cond_seq.sv
module tb_i2c_cond_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW    = 4;
  localparam int HOLD  = 2;
  localparam int SETUP = 3;

  logic clk = 1'b0;
  logic rst, start_set, restart_set, bus_busy, master_mode;
  logic [CW-1:0] high_cnt, low_cnt;
  logic ext_scl;
  logic scl_in, scl_pull, sda_pull, start_pend, restart_pend, busy, cond_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_in = ~(scl_pull | ext_scl);

  i2c_cond_seq #(.CW(CW), .HOLD_CYC(HOLD), .SETUP_CYC(SETUP)) dut (
    .clk(clk), .rst(rst), .start_set(start_set), .restart_set(restart_set),
    .bus_busy(bus_busy), .master_mode(master_mode), .high_cnt(high_cnt),
    .low_cnt(low_cnt), .scl_in(scl_in), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .start_pend(start_pend), .restart_pend(restart_pend),
    .busy(busy), .cond_done(cond_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_len(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_start(input int h, input int l);
    int n = 0, t_sda = -1, t_scl = -1, t_done = -1, nbusy = 0, ndone = 0;
    high_cnt = CW'(h); low_cnt = CW'(l);
    bus_busy = 1'b0; master_mode = 1'b0; ext_scl = 1'b0;
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
    chk(start_pend === 1'b1, "R1 start pend set", int'(start_pend), 1);
    for (int i = 0; i < 200 && t_done < 0; i++) begin
      @(negedge clk);
      n++;
      if (sda_pull && t_sda < 0) begin
        t_sda = n;
        chk(!scl_pull, "R3 sda falls with scl high", int'(scl_pull), 0);
      end
      if (scl_pull && t_scl < 0) t_scl = n;
      if (busy) nbusy++;
      if (cond_done) begin
        t_done = n; ndone++;
        chk(start_pend === 1'b0, "R8 start pend cleared", int'(start_pend), 0);
      end
    end
    chk(t_scl - t_sda == h + HOLD, "R3 hold interval", t_scl - t_sda, h + HOLD);
    chk(t_done - t_scl == lo_len(l) + 3, "R4 low phase", t_done - t_scl, lo_len(l) + 3);
    chk(nbusy == h + HOLD + lo_len(l) + 3, "R9 busy span", nbusy, h + HOLD + lo_len(l) + 3);
    @(negedge clk);
    chk(!cond_done && ndone == 1, "R8 done single cycle", int'(cond_done), 0);
  endtask

  task automatic run_restart(input int h, input int l, input int x);
    int n = 0, t_p1 = -1, t_rel = -1, t_sda = -1, t_scl2 = -1, t_done = -1;
    int st_left = 0;
    bit prev_scl = 1'b0;
    high_cnt = CW'(h); low_cnt = CW'(l);
    bus_busy = 1'b1; master_mode = 1'b1; ext_scl = 1'b1;
    @(negedge clk) restart_set = 1'b1;
    @(negedge clk) restart_set = 1'b0;
    chk(restart_pend === 1'b1, "R2 restart pend set", int'(restart_pend), 1);
    for (int i = 0; i < 300 && t_done < 0; i++) begin
      @(negedge clk);
      n++;
      if (st_left > 0) begin
        st_left--;
        if (st_left == 0) ext_scl = 1'b0;
      end
      if (scl_pull && t_p1 < 0) begin
        t_p1 = n; ext_scl = 1'b0;
        chk(!sda_pull, "R5 sda released first", int'(sda_pull), 0);
      end
      if (prev_scl && !scl_pull && t_rel < 0) begin
        t_rel = n;
        if (x > 0) begin ext_scl = 1'b1; st_left = x; end
      end
      if (sda_pull && t_sda < 0) begin
        t_sda = n;
        chk(!scl_pull, "R7 sda falls with scl high", int'(scl_pull), 0);
      end
      if (scl_pull && t_rel >= 0 && t_scl2 < 0) t_scl2 = n;
      if (cond_done) begin
        t_done = n;
        chk(restart_pend === 1'b0, "R8 restart pend cleared", int'(restart_pend), 0);
      end
      prev_scl = scl_pull;
    end
    chk(t_rel - t_p1 == lo_len(l), "R5 low before release", t_rel - t_p1, lo_len(l));
    chk(t_sda - t_rel == SETUP + 3 + x, "R6 setup interval", t_sda - t_rel, SETUP + 3 + x);
    chk(t_scl2 - t_sda == h + HOLD, "R7 hold interval", t_scl2 - t_sda, h + HOLD);
    chk(t_done - t_scl2 == lo_len(l) + 3, "R7 final low", t_done - t_scl2, lo_len(l) + 3);
  endtask

  task automatic wait_done(input string req);
    int seen = 0;
    for (int i = 0; i < 200 && seen == 0; i++) begin
      @(negedge clk);
      if (cond_done) seen = 1;
    end
    chk(seen == 1, req, seen, 1);
  endtask

  initial begin
    rst = 1'b1; start_set = 1'b0; restart_set = 1'b0; bus_busy = 1'b0;
    master_mode = 1'b0; high_cnt = '0; low_cnt = '0; ext_scl = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(!scl_pull && !sda_pull && !busy && !start_pend && !restart_pend && !cond_done,
        "R10 reset state", int'({scl_pull, sda_pull, busy, start_pend, restart_pend}), 0);

    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++) run_start(h, l);

    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++) run_restart(h, l, 0);
    for (int x = 1; x < 8; x++) run_restart(x, 15 - x, x);

    // R1 start waits on busy bus
    bus_busy = 1'b1; master_mode = 1'b0; ext_scl = 1'b0;
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
    repeat (12) @(negedge clk);
    chk(start_pend && !busy && !sda_pull && !scl_pull, "R1 start held while busy",
        int'({start_pend, busy, sda_pull, scl_pull}), 8);
    bus_busy = 1'b0;
    wait_done("R1 start after bus free");

    // R2 restart waits for master mode
    bus_busy = 1'b1; master_mode = 1'b0; ext_scl = 1'b1;
    @(negedge clk) restart_set = 1'b1;
    @(negedge clk) restart_set = 1'b0;
    repeat (12) @(negedge clk);
    chk(restart_pend && !busy && !sda_pull && !scl_pull, "R2 restart held not master",
        int'({restart_pend, busy, sda_pull, scl_pull}), 8);
    // R2 restart waits while bus free
    bus_busy = 1'b0; master_mode = 1'b1;
    repeat (12) @(negedge clk);
    chk(restart_pend && !busy && !sda_pull && !scl_pull, "R2 restart held bus free",
        int'({restart_pend, busy, sda_pull, scl_pull}), 8);
    bus_busy = 1'b1; ext_scl = 1'b0;
    wait_done("R2 restart after gate opens");
    bus_busy = 1'b0; master_mode = 1'b0;

    // R8 set strobe on the ending edge keeps request pending (h=0,l=0: done on 7th edge)
    high_cnt = '0; low_cnt = '0;
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
    repeat (6) @(negedge clk);
    start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
    chk(cond_done === 1'b1, "R8 done on predicted edge", int'(cond_done), 1);
    chk(start_pend === 1'b1, "R8 set wins over clear", int'(start_pend), 1);
    wait_done("R8 re-armed start runs");

    // R10 reset in mid sequence
    high_cnt = 4'd10; low_cnt = 4'd10;
    @(negedge clk) start_set = 1'b1;
    @(negedge clk) start_set = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_pull === 1'b1, "R10 mid sequence reached", int'(sda_pull), 1);
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(!scl_pull && !sda_pull && !busy && !start_pend && !restart_pend,
        "R10 reset mid sequence", int'({scl_pull, sda_pull, busy, start_pend, restart_pend}), 0);
    repeat (20) @(negedge clk);
    chk(!busy && !cond_done, "R10 stays idle", int'({busy, cond_done}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule